// File: doc/BRIEF.md
# Asynchronous Serial Port with Stop-Bit Framing Check

This block is a full-duplex asynchronous serial port. It has one receiver and one transmitter, and each runs from its own baud tick input. The two directions can therefore work at the same moment and at different rates. Each bit lasts 16 ticks of its direction's tick. A frame carries 8 data bits, or 8 data bits plus a ninth bit, sent least significant bit first between a start bit of 0 and a stop bit of 1.

Software controls the block through an 8-bit control register and a one-byte buffer port. Writing the buffer starts a transmit frame. Received bytes land in `rx_buf`.

The framing check is optional and is turned on by the `err_chk_en` level input. When it is on:
- the receiver checks every stop bit;
- a stop bit of 0 raises a sticky error flag;
- the received-data flag rises one bit later, at the stop bit;
- the top bit of the control register shows the error flag instead of the width-select bit.

Top module: `async_serial_port`

## Requirements
- R1: Control register layout (write with `wr_sel`=0, read on `ctrl_rd`): [7] width select / error flag, [6] spare mode bit, [5] spare bit (stored only), [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done flag, [0] receive-full flag. Width select 0 gives 8-bit frames and 1 gives 9-bit frames. Data is LSB first, and the received byte appears on `rx_buf`.
- R2: While receive enable is 0, incoming frames are ignored: the receive-full flag and `rx_buf` stay unchanged.
- R3: Each bit is 16 receive ticks long. Its value is the 2-of-3 majority of samples 7, 8 and 9 counted from the start-bit detection tick. A start bit whose majority reads 1 is dropped as a glitch. A single-sample spike inside a data bit does not change the received value.
- R4: With the check on, a stop bit of 0 sets the error flag. With the check off, the error flag is never set by hardware.
- R5: The error flag is sticky. Later frames with good stop bits leave it at 1. Only a register write of 0 (with the check on) or a reset clears it.
- R6: Bit 7 of the control register reads and writes the error flag when `err_chk_en`=1, and the width-select bit when `err_chk_en`=0.
- R7: The receive-full flag rises at the majority decision of the last data bit when the check is off, and at the decision of the stop bit when the check is on.
- R8: If the receive-full flag is already 1 at the load point, the frame is dropped: `rx_buf` is kept, but the stop-bit check still updates the error flag.
- R9: The received ninth bit holds the ninth data bit in 9-bit frames and the stop bit in 8-bit frames.
- R10: Writing the buffer (`wr_sel`=1) while the transmitter is idle sends: 0, then the 8 data bits LSB first, then the transmit ninth bit in 9-bit mode, then 1. The transmit-done flag is set as the stop bit starts. Buffer writes made while a frame is in flight are ignored.
- R11: Transmit and receive run at the same time from independent ticks without disturbing each other.
- R12: After reset, `ctrl_rd` and `rx_buf` are 0 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_rx_tick | input | 1 | Receive oversampling tick, 16 per bit |
| baud_tx_tick | input | 1 | Transmit tick, 16 per bit |
| err_chk_en | input | 1 | Stop-bit check enable and bit-7 view select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = transmit buffer |
| wr_data | input | 8 | Write data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ctrl_rd | output | 8 | Control register read value |
| rx_buf | output | 8 | Last accepted received byte |

## Verification
The receive line passes through two synchronizer stages. One further cycle leads to start detection, so the majority decision of bit b lands 12 + 16·b clocks after the start bit is driven. The flag register updates on that same edge. The bench therefore reads the receive-full flag at clock 11 and clock 14 of the last data bit and of the stop bit, and the two enable settings give opposite answers at those points. The transmit line is decoded at mid-bit by counting whole transmit bit periods from the falling edge. This keeps every sample well away from the few-cycle phase offset of the tick. Buffer, ninth-bit and error-flag checks are made only after the stop bit has ended.

// File: rtl/uart_sp_pkg.sv
package uart_sp_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // control register bit positions
  localparam int CTL_WIDTH_ERR = 7;
  localparam int CTL_MODE_LO   = 6;
  localparam int CTL_SPARE     = 5;
  localparam int CTL_RX_EN     = 4;
  localparam int CTL_TX_B9     = 3;
  localparam int CTL_RX_B9     = 2;
  localparam int CTL_TX_DONE   = 1;
  localparam int CTL_RX_FULL   = 0;

endpackage

// File: rtl/uart_sp_sync.sv
module uart_sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/uart_sp_rx.sv
module uart_sp_rx
  import uart_sp_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          ren,
  input  logic          nine,
  output logic          last_evt,
  output logic          stop_evt,
  output logic          bit_val,
  output logic [DW-1:0] word,
  output logic          b9
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 3);
  localparam logic [CW-1:0] S_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] S_C   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] S_END = CW'(OVS - 1);
  localparam logic [IW-1:0] I_LAST8 = IW'(DW);
  localparam logic [IW-1:0] I_B9    = IW'(DW + 1);
  localparam logic [IW-1:0] I_STOP9 = IW'(DW + 2);

  rx_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [1:0]    smp_q, smp_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          b9_q, b9_n;
  logic [IW-1:0] stop_idx;
  logic          maj;

  assign stop_idx = nine ? I_STOP9 : I_B9;
  assign maj = (smp_q[0] & smp_q[1]) | (smp_q[0] & rxd_s) | (smp_q[1] & rxd_s);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    smp_n    = smp_q;
    sh_n     = sh_q;
    b9_n     = b9_q;
    last_evt = 1'b0;
    stop_evt = 1'b0;
    if (!ren) begin
      st_n = RX_IDLE;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_n  = RX_RUN;
            cnt_n = '0;
            idx_n = '0;
          end
        end
        default: begin
          cnt_n = (cnt_q == S_END) ? '0 : cnt_q + 1'b1;
          if (cnt_q == S_END) idx_n = idx_q + 1'b1;
          if (cnt_q == S_A) smp_n[0] = rxd_s;
          if (cnt_q == S_B) smp_n[1] = rxd_s;
          if (cnt_q == S_C) begin
            if (idx_q == '0) begin
              if (maj) st_n = RX_IDLE;
            end else if (idx_q == stop_idx) begin
              stop_evt = 1'b1;
              st_n     = RX_IDLE;
            end else if (idx_q == I_B9) begin
              b9_n     = maj;
              last_evt = 1'b1;
            end else begin
              sh_n = {maj, sh_q[DW-1:1]};
              if (!nine && idx_q == I_LAST8) last_evt = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      smp_q <= '0;
      sh_q  <= '0;
      b9_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      smp_q <= smp_n;
      sh_q  <= sh_n;
      b9_q  <= b9_n;
    end
  end

  assign word    = sh_n;
  assign b9      = b9_n;
  assign bit_val = maj;

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_RUN && ren && tick && idx_q == '0 && cnt_q == S_C && maj) |=> (st_q == RX_IDLE)); // R3

endmodule

// File: rtl/uart_sp_tx.sv
module uart_sp_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          b9,
  input  logic          nine,
  output logic          txd,
  output logic          ti_set
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 3);
  localparam logic [CW-1:0] S_END   = CW'(OVS - 1);
  localparam logic [IW-1:0] I_STOP8 = IW'(DW + 1);
  localparam logic [IW-1:0] I_STOP9 = IW'(DW + 2);

  logic          busy_q, busy_n;
  logic          nine_q, nine_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW:0]   frm_q, frm_n;
  logic [IW-1:0] stop_idx;

  assign stop_idx = nine_q ? I_STOP9 : I_STOP8;

  always_comb begin
    busy_n = busy_q;
    nine_n = nine_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    frm_n  = frm_q;
    ti_set = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        nine_n = nine;
        cnt_n  = '0;
        idx_n  = '0;
        frm_n  = {b9, data};
      end
    end else if (tick) begin
      cnt_n = (cnt_q == S_END) ? '0 : cnt_q + 1'b1;
      if (cnt_q == S_END) begin
        if (idx_q == stop_idx) begin
          busy_n = 1'b0;
        end else begin
          idx_n = idx_q + 1'b1;
          if (idx_q != '0) frm_n = {1'b0, frm_q[DW:1]};
          if (idx_q + 1'b1 == stop_idx) ti_set = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nine_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      frm_q  <= '0;
    end else begin
      busy_q <= busy_n;
      nine_q <= nine_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      frm_q  <= frm_n;
    end
  end

  always_comb begin
    if (!busy_q)                txd = 1'b1;
    else if (idx_q == '0)       txd = 1'b0;
    else if (idx_q == stop_idx) txd = 1'b1;
    else                        txd = frm_q[0];
  end

endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import uart_sp_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int DW      = 8,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_rx_tick,
  input  logic          baud_tx_tick,
  input  logic          err_chk_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          rxd,
  output logic          txd,
  output logic [7:0]    ctrl_rd,
  output logic [DW-1:0] rx_buf
);

  logic rxd_s;
  logic last_evt, stop_evt, bit_val, rx_b9, ti_set;
  logic [DW-1:0] rx_word;

  logic wsel_q, wsel_n, sm1_q, sm1_n, spare_q, spare_n, ren_q, ren_n;
  logic tb8_q, tb8_n, rb8_q, rb8_n, ti_q, ti_n, ri_q, ri_n;
  logic fe_q, fe_n, acc_q, acc_n;
  logic [DW-1:0] buf_q, buf_n;
  logic ctl_wr, buf_wr, load_evt;

  assign ctl_wr   = wr_en & ~wr_sel;
  assign buf_wr   = wr_en & wr_sel;
  assign load_evt = err_chk_en ? stop_evt : last_evt;

  uart_sp_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  uart_sp_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_rx_tick), .rxd_s(rxd_s),
    .ren(ren_q), .nine(wsel_q), .last_evt(last_evt), .stop_evt(stop_evt),
    .bit_val(bit_val), .word(rx_word), .b9(rx_b9)
  );

  uart_sp_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tx_tick), .start(buf_wr),
    .data(wr_data[DW-1:0]), .b9(tb8_q), .nine(wsel_q), .txd(txd), .ti_set(ti_set)
  );

  always_comb begin
    wsel_n  = wsel_q;
    sm1_n   = sm1_q;
    spare_n = spare_q;
    ren_n   = ren_q;
    tb8_n   = tb8_q;
    rb8_n   = rb8_q;
    ti_n    = ti_q;
    ri_n    = ri_q;
    fe_n    = fe_q;
    acc_n   = acc_q;
    buf_n   = buf_q;
    if (ctl_wr) begin
      if (err_chk_en) fe_n   = wr_data[CTL_WIDTH_ERR];
      else            wsel_n = wr_data[CTL_WIDTH_ERR];
      sm1_n   = wr_data[CTL_MODE_LO];
      spare_n = wr_data[CTL_SPARE];
      ren_n   = wr_data[CTL_RX_EN];
      tb8_n   = wr_data[CTL_TX_B9];
      rb8_n   = wr_data[CTL_RX_B9];
      ti_n    = wr_data[CTL_TX_DONE];
      ri_n    = wr_data[CTL_RX_FULL];
    end
    if (load_evt) begin
      if (!ri_q) begin
        buf_n = rx_word;
        ri_n  = 1'b1;
        acc_n = 1'b1;
        if (wsel_q)        rb8_n = rx_b9;
        else if (stop_evt) rb8_n = bit_val;
      end else begin
        acc_n = 1'b0;
      end
    end
    if (stop_evt && !err_chk_en && !wsel_q && acc_q) rb8_n = bit_val;
    if (stop_evt && err_chk_en && !bit_val) fe_n = 1'b1;
    if (ti_set) ti_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q  <= 1'b0;
      sm1_q   <= 1'b0;
      spare_q <= 1'b0;
      ren_q   <= 1'b0;
      tb8_q   <= 1'b0;
      rb8_q   <= 1'b0;
      ti_q    <= 1'b0;
      ri_q    <= 1'b0;
      fe_q    <= 1'b0;
      acc_q   <= 1'b0;
      buf_q   <= '0;
    end else begin
      wsel_q  <= wsel_n;
      sm1_q   <= sm1_n;
      spare_q <= spare_n;
      ren_q   <= ren_n;
      tb8_q   <= tb8_n;
      rb8_q   <= rb8_n;
      ti_q    <= ti_n;
      ri_q    <= ri_n;
      fe_q    <= fe_n;
      acc_q   <= acc_n;
      buf_q   <= buf_n;
    end
  end

  assign ctrl_rd = {(err_chk_en ? fe_q : wsel_q), sm1_q, spare_q, ren_q,
                    tb8_q, rb8_q, ti_q, ri_q};
  assign rx_buf  = buf_q;

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !ctl_wr) |=> fe_q); // R5
  AST_FE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fe_q) && !$past(ctl_wr)) |-> $past(err_chk_en)); // R4
  AST_RI_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ri_q |=> $stable(buf_q)); // R8
  AST_LOAD_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri_q) && !$past(ctl_wr)) |-> $past(ren_q)); // R2
  AST_TI_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti_q) && !$past(ctl_wr)) |-> txd); // R10

endmodule

// File: tb/async_serial_port_tb.sv
module async_serial_port_tb;

  logic       clk, rst_n, baud_rx_tick, baud_tx_tick, err_chk_en;
  logic       wr_en, wr_sel, rxd, txd;
  logic [7:0] wr_data, ctrl_rd, rx_buf;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  logic ri_a, ri_b, ri_c, ri_d;
  logic fe_exp;
  logic mon_nine, mon_done, mon_start, mon_stop, mon_ti_pre, mon_ti_stop;
  logic [8:0] mon_word;

  // {check on, 9-bit, stop bit, ninth+data}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 9'h0A5},
    {1'b0, 1'b0, 1'b0, 9'h03C},
    {1'b1, 1'b0, 1'b1, 9'h081},
    {1'b1, 1'b0, 1'b0, 9'h07E},
    {1'b1, 1'b0, 1'b1, 9'h055},
    {1'b1, 1'b1, 1'b1, 9'h1C3},
    {1'b0, 1'b1, 1'b1, 9'h00F},
    {1'b0, 1'b1, 1'b0, 9'h1F0}
  };

  async_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .baud_rx_tick(baud_rx_tick), .baud_tx_tick(baud_tx_tick),
    .err_chk_en(err_chk_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rxd(rxd), .txd(txd), .ctrl_rd(ctrl_rd), .rx_buf(rx_buf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    baud_tx_tick = 1'b0;
    forever begin
      @(negedge clk) baud_tx_tick = 1'b1;
      @(negedge clk) baud_tx_tick = 1'b0;
      @(negedge clk) baud_tx_tick = 1'b0;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic bitval(input logic [8:0] d, input logic nine,
                                  input logic stopb, input int b);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    if (b == 9 && nine) return d[8];
    return stopb;
  endfunction

  task automatic send_rx(input logic [8:0] d, input logic nine, input logic stopb,
                         input int spike);
    int last;
    int nb;
    last = nine ? 9 : 8;
    nb   = last + 2;
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < 16; s++) begin
        int pos;
        pos = 16 * b + s;
        @(negedge clk);
        if (s == 0) rxd = bitval(d, nine, stopb, b);
        if (pos == spike) rxd = ~rxd;
        if (pos == spike + 1) rxd = bitval(d, nine, stopb, b);
        if (pos == 16 * last + 11)       ri_a = ctrl_rd[0];
        if (pos == 16 * last + 14)       ri_b = ctrl_rd[0];
        if (pos == 16 * (last + 1) + 11) ri_c = ctrl_rd[0];
        if (pos == 16 * (last + 1) + 14) ri_d = ctrl_rd[0];
      end
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // transmit line monitor, samples at mid-bit (48 clocks per bit)
  initial begin
    mon_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        int nb;
        nb = mon_nine ? 9 : 8;
        repeat (23) @(negedge clk);
        mon_start = txd;
        mon_word  = '0;
        for (int i = 0; i < nb; i++) begin
          repeat (48) @(negedge clk);
          mon_word[i] = txd;
          if (i == nb - 1) mon_ti_pre = ctrl_rd[1];
        end
        repeat (48) @(negedge clk);
        mon_stop    = txd;
        mon_ti_stop = ctrl_rd[1];
        mon_done    = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; baud_rx_tick = 1'b1; err_chk_en = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rxd = 1'b1;
    mon_nine = 1'b0; fe_exp = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ctrl reset", 16'(ctrl_rd), 16'h00);
    chk("R12 rx_buf reset", 16'(rx_buf), 16'h00);
    chk("R12 txd idle", 16'(txd), 16'h1);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic fe, nine, stopb;
      logic [8:0] d;
      {fe, nine, stopb, d} = VEC[v];
      err_chk_en = 1'b0;
      wr(1'b0, {nine, 1'b1, 1'b0, 1'b1, 4'b0000});
      err_chk_en = fe;
      send_rx(d, nine, stopb, -100);
      if (fe && !stopb) fe_exp = 1'b1;
      if (!fe) begin
        chk("R7 RI low before last data decision", 16'(ri_a), 16'h0);
        chk("R7 RI high after last data bit", 16'(ri_b), 16'h1);
      end else begin
        chk("R7 RI low during last data bit", 16'(ri_b), 16'h0);
        chk("R7 RI low before stop decision", 16'(ri_c), 16'h0);
        chk("R7 RI high at stop bit", 16'(ri_d), 16'h1);
      end
      chk("R1 received byte", 16'(rx_buf), 16'(d[7:0]));
      chk("R9 received ninth bit", 16'(ctrl_rd[2]), 16'(nine ? d[8] : stopb));
      chk("R4 R5 R6 bit7 view", 16'(ctrl_rd[7]), 16'(fe ? fe_exp : nine));
    end

    // R2: receiver disabled
    err_chk_en = 1'b0;
    wr(1'b0, 8'b0100_0000);
    send_rx(9'h099, 1'b0, 1'b1, -100);
    chk("R2 RI stays clear with REN=0", 16'(ctrl_rd[0]), 16'h0);
    chk("R2 rx_buf unchanged with REN=0", 16'(rx_buf), 16'hF0);

    // R3: start glitch, then spike inside a data bit
    wr(1'b0, 8'b0101_0000);
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 start glitch ignored", 16'(ctrl_rd[0]), 16'h0);
    send_rx(9'h096, 1'b0, 1'b1, 16 * 3 + 8);
    chk("R3 majority rejects spike", 16'(rx_buf), 16'h96);

    // R5/R8: clear FE by write, then drop with RI held
    err_chk_en = 1'b1;
    wr(1'b0, 8'b0101_0000);
    chk("R5 FE cleared by write", 16'(ctrl_rd[7]), 16'h0);
    send_rx(9'h022, 1'b0, 1'b1, -100);
    chk("R8 first frame loaded", 16'(rx_buf), 16'h22);
    send_rx(9'h011, 1'b0, 1'b0, -100);
    chk("R8 buffer kept while RI set", 16'(rx_buf), 16'h22);
    chk("R8 FE still set on dropped frame", 16'(ctrl_rd[7]), 16'h1);
    err_chk_en = 1'b0;
    @(negedge clk);
    chk("R6 bit7 shows width select", 16'(ctrl_rd[7]), 16'h0);
    err_chk_en = 1'b1;
    @(negedge clk);
    chk("R6 bit7 shows FE", 16'(ctrl_rd[7]), 16'h1);

    // R10/R11: transmit 9-bit while receiving
    err_chk_en = 1'b0;
    wr(1'b0, 8'b1101_1000);
    mon_nine = 1'b1;
    mon_done = 1'b0;
    wr(1'b1, 8'h6A);
    wr(1'b1, 8'hFF);
    send_rx(9'h13D, 1'b1, 1'b1, -100);
    chk("R11 rx during tx byte", 16'(rx_buf), 16'h3D);
    chk("R11 rx during tx ninth", 16'(ctrl_rd[2]), 16'h1);
    while (!mon_done) @(negedge clk);
    chk("R10 tx start bit", 16'(mon_start), 16'h0);
    chk("R10 tx data and ninth bit", 16'(mon_word), 16'h16A);
    chk("R10 tx stop bit", 16'(mon_stop), 16'h1);
    chk("R10 TI low before stop", 16'(mon_ti_pre), 16'h0);
    chk("R10 TI set at stop", 16'(mon_ti_stop), 16'h1);

    finish_run();
  end

endmodule